// File: doc/BRIEF.md
# Camera Capture Front End

This block receives a parallel image-sensor bus (a pixel clock, a line-active level, a frame-start pulse and an 8-bit data byte) and hands the captured bytes to the system clock domain as a valid/ready stream. The crossing goes through an asynchronous FIFO whose read and write pointers pass between the domains in Gray code through two-flop synchronizers. A processor reaches the block through a simple word-register port with address, read, write and data signals. Through that port it starts a capture, picks single-frame or free-running mode, and reads the geometry and rate of the incoming video.

Capture never begins part-way through a frame. After software sets the arm bit, the first byte taken belongs to the frame opened by the next rising edge of the frame pulse. Geometry is measured continuously, whether or not capture is armed, so software can read the sensor's line length and line count and size its buffers before it arms. A resolution-stable flag reports when two frames in a row have matched.

On the output stream a byte is transferred on a system-clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` hold. When the consumer stalls long enough to fill the FIFO, new bytes are discarded and an error flag records the loss. Back-pressure is never passed to the camera. A single active-low asynchronous reset clears both clock domains.

Top module: `cam_capture_top`

## Requirements
- R1: After reset, `out_valid` is 0. The registers at byte offsets 0x0, 0x4, 0x8, 0xC and 0x10 read 0, and offset 0x14 reads the window default (200000000). Read data is valid on the cycle after `reg_read` is sampled high.
- R2: Writing bit 0 (arm) of offset 0x0 does not capture the rest of the frame in progress. Capture starts at the next rising edge of `cam_frame`.
- R3: With bit 1 of offset 0x0 clear (single-frame mode), exactly one frame is captured per arm. The arm bit must be written 0 and then 1 again before another frame is taken. With bit 1 set, every frame is captured for as long as arm stays 1.
- R4: A byte is stored only on a pixel-clock edge where capture is active and `cam_line` is high. Bytes leave in arrival order. While `out_valid` is 1 and `out_ready` is 0, both `out_valid` and `out_data` hold.
- R5: A byte that arrives while the FIFO is full is discarded and sets sticky bit 1 of offset 0x4. Writing 1 to that bit clears it, but a discard that coincides with the clear leaves the bit set.
- R6: On every rising edge of `cam_frame`, offset 0x8 takes the length in pixels of the last line of the frame just ended, and offset 0xC takes its number of lines.
- R7: Bit 2 of offset 0x4 is 1 when the two most recent measurements match in both pixels per line and lines per frame, and the line count is nonzero. Otherwise it is 0.
- R8: Offset 0x10 holds the number of `cam_frame` rising edges seen during the last completed window of N system-clock cycles, where N is held at offset 0x14. Writing offset 0x14 restarts the window.
- R9: Bit 0 of offset 0x4 is 1 while a frame is being captured and 0 otherwise.
- R10: The FIFO holds exactly 512 bytes. With the output stalled, the first 512 bytes of a longer capture come out intact and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock: register port and output stream |
| pix_clk | input | 1 | Camera pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| cam_line | input | 1 | High while a line's active pixels are on the bus |
| cam_frame | input | 1 | Frame pulse; rising edge opens a frame |
| cam_data | input | 8 | Pixel byte, sampled on pix_clk |
| reg_addr | input | 5 | Byte address of the register word |
| reg_write | input | 1 | Write strobe |
| reg_read | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Output byte |

## Verification
The overflow flag has two sources that can act in the same system-clock cycle: a software write-1-to-clear and a discard event arriving from the pixel domain. The bench stalls the output so the FIFO fills, then issues the clear in the middle of a line while a byte is being discarded on every pixel clock. The flag read afterwards must still be set, because discards continue through the clear and the set takes priority. Once the pixel stream has stopped, the same clear must leave the flag at 0.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [2:0] {
    RIX_CTRL = 3'd0,
    RIX_STAT = 3'd1,
    RIX_PPL  = 3'd2,
    RIX_LPF  = 3'd3,
    RIX_RATE = 3'd4,
    RIX_WIN  = 3'd5
  } reg_ix_e;

  localparam int CTRL_ARM_BIT  = 0;
  localparam int CTRL_CONT_BIT = 1;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_OVF_BIT  = 1;
  localparam int STAT_RES_BIT  = 2;
endpackage

// File: rtl/cam_xfifo.sv
module cam_xfifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 512
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_w1, rg_w2, wg_r1, wg_r2;
  logic [PW-1:0] wbin_n, rbin_n;
  logic          do_push, do_pop;

  assign wbin_n  = wbin + 1'b1;
  assign rbin_n  = rbin + 1'b1;
  assign full    = (wgray == {~rg_w2[PW-1:PW-2], rg_w2[PW-3:0]});
  assign empty   = (rgray == wg_r2);
  assign do_push = wen && !full;
  assign do_pop  = ren && !empty;
  assign rdata   = mem[rbin[AW-1:0]];

  always_ff @(posedge wclk) begin
    if (do_push) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_w1 <= '0;
      rg_w2 <= '0;
    end else begin
      rg_w1 <= rgray;
      rg_w2 <= rg_w1;
      if (do_push) begin
        wbin  <= wbin_n;
        wgray <= wbin_n ^ (wbin_n >> 1);
      end
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_r1 <= '0;
      wg_r2 <= '0;
    end else begin
      wg_r1 <= wgray;
      wg_r2 <= wg_r1;
      if (do_pop) begin
        rbin  <= rbin_n;
        rgray <= rbin_n ^ (rbin_n >> 1);
      end
    end
  end
endmodule

// File: rtl/cam_pix_front.sv
module cam_pix_front #(
  parameter int DW    = 8,
  parameter int CNT_W = 16
) (
  input  logic             pix_clk,
  input  logic             rst_n,
  input  logic             cam_line,
  input  logic             cam_frame,
  input  logic [DW-1:0]    cam_data,
  input  logic             arm,
  input  logic             cont,
  input  logic             fifo_full,
  output logic             push,
  output logic [DW-1:0]    push_data,
  output logic             active,
  output logic             vs_rise,
  output logic [CNT_W-1:0] snap_px,
  output logic [CNT_W-1:0] snap_lines,
  output logic             frame_tog,
  output logic             drop_tog
);
  logic [1:0]       arm_s, cont_s;
  logic             line_q, line_qq, frame_q, frame_qq;
  logic [DW-1:0]    data_q;
  logic             shot_used;
  logic [CNT_W-1:0] px_cnt, last_px, line_cnt;
  logic             line_fall, push_req;

  assign vs_rise   = frame_q & ~frame_qq;
  assign line_fall = line_qq & ~line_q;
  assign push_req  = active & line_q;
  assign push      = push_req & ~fifo_full;
  assign push_data = data_q;

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_s      <= '0;
      cont_s     <= '0;
      line_q     <= 1'b0;
      line_qq    <= 1'b0;
      frame_q    <= 1'b0;
      frame_qq   <= 1'b0;
      data_q     <= '0;
      active     <= 1'b0;
      shot_used  <= 1'b0;
      px_cnt     <= '0;
      last_px    <= '0;
      line_cnt   <= '0;
      snap_px    <= '0;
      snap_lines <= '0;
      frame_tog  <= 1'b0;
      drop_tog   <= 1'b0;
    end else begin
      arm_s    <= {arm_s[0], arm};
      cont_s   <= {cont_s[0], cont};
      line_q   <= cam_line;
      line_qq  <= line_q;
      frame_q  <= cam_frame;
      frame_qq <= frame_q;
      data_q   <= cam_data;

      if (vs_rise) active <= arm_s[1] && (cont_s[1] || !shot_used);

      if (!arm_s[1])                   shot_used <= 1'b0;
      else if (vs_rise && !cont_s[1])  shot_used <= 1'b1;

      if (line_q) px_cnt <= px_cnt + 1'b1;
      else        px_cnt <= '0;
      if (line_fall) last_px <= px_cnt;

      if (vs_rise) begin
        snap_px    <= last_px;
        snap_lines <= line_cnt;
        line_cnt   <= '0;
        frame_tog  <= ~frame_tog;
      end else if (line_fall) begin
        line_cnt <= line_cnt + 1'b1;
      end

      if (push_req && fifo_full) drop_tog <= ~drop_tog;
    end
  end
endmodule

// File: rtl/cam_csr.sv
module cam_csr
  import cam_pkg::*;
#(
  parameter int          CNT_W   = 16,
  parameter int          WIN_W   = 32,
  parameter int unsigned WIN_RST = 200000000
) (
  input  logic             sys_clk,
  input  logic             rst_n,
  input  logic [4:0]       reg_addr,
  input  logic             reg_write,
  input  logic             reg_read,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             arm,
  output logic             cont,
  input  logic             active_pix,
  input  logic [CNT_W-1:0] snap_px,
  input  logic [CNT_W-1:0] snap_lines,
  input  logic             frame_tog,
  input  logic             drop_tog,
  output logic             st_ovf,
  output logic             st_res,
  output logic [CNT_W-1:0] st_lines,
  output logic [WIN_W-1:0] st_win
);
  logic [1:0]       ctrl_q;
  logic [1:0]       busy_s;
  logic [2:0]       ftog_s, dtog_s;
  logic             frame_evt, drop_evt;
  logic [CNT_W-1:0] px_q, lines_q, rate_q, edge_cnt;
  logic             ovf_q, res_q;
  logic [WIN_W-1:0] win_q, win_cnt;
  logic             win_end, wr_ctrl, wr_stat, wr_win, ovf_clr;
  logic [2:0]       ix;
  logic [31:0]      rd_mux;

  assign ix        = reg_addr[4:2];
  assign wr_ctrl   = reg_write && (ix == RIX_CTRL);
  assign wr_stat   = reg_write && (ix == RIX_STAT);
  assign wr_win    = reg_write && (ix == RIX_WIN);
  assign ovf_clr   = wr_stat && reg_wdata[STAT_OVF_BIT];
  assign frame_evt = ftog_s[2] ^ ftog_s[1];
  assign drop_evt  = dtog_s[2] ^ dtog_s[1];
  assign win_end   = (win_cnt + 1'b1) >= win_q;
  assign arm       = ctrl_q[CTRL_ARM_BIT];
  assign cont      = ctrl_q[CTRL_CONT_BIT];
  assign st_ovf    = ovf_q;
  assign st_res    = res_q;
  assign st_lines  = lines_q;
  assign st_win    = win_q;

  always_comb begin
    rd_mux = '0;
    case (ix)
      RIX_CTRL: rd_mux = {30'd0, ctrl_q};
      RIX_STAT: rd_mux = {29'd0, res_q, ovf_q, busy_s[1]};
      RIX_PPL:  rd_mux = 32'(px_q);
      RIX_LPF:  rd_mux = 32'(lines_q);
      RIX_RATE: rd_mux = 32'(rate_q);
      RIX_WIN:  rd_mux = 32'(win_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      busy_s    <= '0;
      ftog_s    <= '0;
      dtog_s    <= '0;
      px_q      <= '0;
      lines_q   <= '0;
      rate_q    <= '0;
      edge_cnt  <= '0;
      ovf_q     <= 1'b0;
      res_q     <= 1'b0;
      win_q     <= WIN_W'(WIN_RST);
      win_cnt   <= '0;
      reg_rdata <= '0;
    end else begin
      busy_s <= {busy_s[0], active_pix};
      ftog_s <= {ftog_s[1:0], frame_tog};
      dtog_s <= {dtog_s[1:0], drop_tog};

      if (reg_read) reg_rdata <= rd_mux;
      if (wr_ctrl)  ctrl_q <= reg_wdata[1:0];

      ovf_q <= (ovf_q & ~ovf_clr) | drop_evt;

      if (frame_evt) begin
        px_q    <= snap_px;
        lines_q <= snap_lines;
        res_q   <= (snap_lines != '0) && (snap_px == px_q) && (snap_lines == lines_q);
      end

      if (wr_win) begin
        win_q    <= reg_wdata[WIN_W-1:0];
        win_cnt  <= '0;
        edge_cnt <= '0;
      end else if (win_end) begin
        rate_q   <= edge_cnt + CNT_W'(frame_evt);
        edge_cnt <= '0;
        win_cnt  <= '0;
      end else begin
        win_cnt  <= win_cnt + 1'b1;
        edge_cnt <= edge_cnt + CNT_W'(frame_evt);
      end
    end
  end
endmodule

// File: rtl/cam_capture_top.sv
module cam_capture_top #(
  parameter int          DW         = 8,
  parameter int          FIFO_DEPTH = 512,
  parameter int          CNT_W      = 16,
  parameter int          WIN_W      = 32,
  parameter int unsigned WIN_RST    = 200000000
) (
  input  logic          sys_clk,
  input  logic          pix_clk,
  input  logic          rst_n,
  input  logic          cam_line,
  input  logic          cam_frame,
  input  logic [DW-1:0] cam_data,
  input  logic [4:0]    reg_addr,
  input  logic          reg_write,
  input  logic          reg_read,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic             arm, cont, fifo_full, fifo_empty, push, active, vs_rise;
  logic             frame_tog, drop_tog;
  logic [DW-1:0]    push_data;
  logic [CNT_W-1:0] snap_px, snap_lines, st_lines;
  logic             st_ovf, st_res;
  logic [WIN_W-1:0] st_win;

  assign out_valid = ~fifo_empty;

  cam_pix_front #(.DW(DW), .CNT_W(CNT_W)) u_front (
    .pix_clk(pix_clk), .rst_n(rst_n), .cam_line(cam_line), .cam_frame(cam_frame),
    .cam_data(cam_data), .arm(arm), .cont(cont), .fifo_full(fifo_full),
    .push(push), .push_data(push_data), .active(active), .vs_rise(vs_rise),
    .snap_px(snap_px), .snap_lines(snap_lines), .frame_tog(frame_tog), .drop_tog(drop_tog)
  );

  cam_xfifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .wclk(pix_clk), .rclk(sys_clk), .rst_n(rst_n),
    .wen(push), .wdata(push_data), .full(fifo_full),
    .ren(out_ready), .rdata(out_data), .empty(fifo_empty)
  );

  cam_csr #(.CNT_W(CNT_W), .WIN_W(WIN_W), .WIN_RST(WIN_RST)) u_csr (
    .sys_clk(sys_clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_write(reg_write),
    .reg_read(reg_read), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .arm(arm), .cont(cont), .active_pix(active), .snap_px(snap_px),
    .snap_lines(snap_lines), .frame_tog(frame_tog), .drop_tog(drop_tog),
    .st_ovf(st_ovf), .st_res(st_res), .st_lines(st_lines), .st_win(st_win)
  );
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk #(
  parameter int DW    = 8,
  parameter int CNT_W = 16,
  parameter int WIN_W = 32
) (
  input logic             sys_clk,
  input logic             pix_clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_data,
  input logic [4:0]       reg_addr,
  input logic             reg_write,
  input logic             reg_read,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             st_ovf,
  input logic             st_res,
  input logic [CNT_W-1:0] st_lines,
  input logic [WIN_W-1:0] st_win,
  input logic             active,
  input logic             vs_rise
);
  AST_STREAM_HOLD: assert property (@(posedge sys_clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R4

  AST_OVF_STICKY: assert property (@(posedge sys_clk) disable iff (!rst_n)
    st_ovf && !(reg_write && reg_addr == 5'h04 && reg_wdata[1]) |=> st_ovf); // R5

  AST_RES_NONZERO: assert property (@(posedge sys_clk) disable iff (!rst_n)
    st_res |-> st_lines != '0); // R7

  AST_WIN_READBACK: assert property (@(posedge sys_clk) disable iff (!rst_n)
    reg_read && !reg_write && reg_addr == 5'h14 |=> reg_rdata == 32'($past(st_win))); // R8

  AST_START_AT_FRAME: assert property (@(posedge pix_clk) disable iff (!rst_n)
    $rose(active) |-> $past(vs_rise)); // R2
endmodule

bind cam_capture_top cam_capture_chk #(.DW(DW), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_chk (
  .sys_clk(sys_clk), .pix_clk(pix_clk), .rst_n(rst_n),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .reg_addr(reg_addr), .reg_write(reg_write), .reg_read(reg_read),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .st_ovf(st_ovf), .st_res(st_res), .st_lines(st_lines), .st_win(st_win),
  .active(active), .vs_rise(vs_rise)
);

// File: tb/cam_capture_top_bench.sv
`timescale 1ns/1ps
module cam_capture_top_bench;
  logic        sys_clk = 1'b0;
  logic        pix_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cam_line = 1'b0, cam_frame = 1'b0;
  logic [7:0]  cam_data = '0;
  logic [4:0]  reg_addr = '0;
  logic        reg_write = 1'b0, reg_read = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        out_valid, out_ready = 1'b0;
  logic [7:0]  out_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] dbyte = 8'd0;

  localparam int NTBL = 6;
  localparam int TBL_PX [NTBL] = '{6, 6, 5, 7, 7, 7};
  localparam int TBL_LN [NTBL] = '{4, 4, 3, 2, 2, 2};

  always #2.5 sys_clk = ~sys_clk;
  always #15  pix_clk = ~pix_clk;

  cam_capture_top u_cam_capture_top (
    .sys_clk(sys_clk), .pix_clk(pix_clk), .rst_n(rst_n),
    .cam_line(cam_line), .cam_frame(cam_frame), .cam_data(cam_data),
    .reg_addr(reg_addr), .reg_write(reg_write), .reg_read(reg_read),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge pix_clk);
  endtask

  task automatic send_vsync();
    cam_frame = 1'b1; tick(2);
    cam_frame = 1'b0; tick(3);
  endtask

  task automatic send_lines(int ln, int px);
    for (int l = 0; l < ln; l++) begin
      cam_line = 1'b1;
      for (int p = 0; p < px; p++) begin
        cam_data = dbyte;
        tick(1);
        dbyte++;
      end
      cam_line = 1'b0;
      tick(3);
    end
  endtask

  task automatic reg_wr(int a, int d);
    @(negedge sys_clk);
    reg_addr = 5'(a); reg_wdata = 32'(d); reg_write = 1'b1;
    @(negedge sys_clk);
    reg_write = 1'b0;
  endtask

  task automatic reg_rd(int a, output logic [31:0] v);
    @(negedge sys_clk);
    reg_addr = 5'(a); reg_read = 1'b1;
    @(negedge sys_clk);
    reg_read = 1'b0;
    v = reg_rdata;
  endtask

  task automatic rearm(bit cont);
    reg_wr(0, 0); tick(4);
    reg_wr(0, cont ? 3 : 1); tick(4);
  endtask

  task automatic drain(string tag, logic [7:0] first, int exp_cnt);
    int n = 0, idle = 0, bad = 0;
    logic [7:0] e = first;
    @(negedge sys_clk);
    out_ready = 1'b1;
    while (idle < 60) begin
      if (out_valid) begin
        if (out_data !== e) bad++;
        e++; n++; idle = 0;
      end else idle++;
      @(negedge sys_clk);
    end
    out_ready = 1'b0;
    chk({tag, " count"}, n, exp_cnt);
    chk({tag, " order"}, bad, 0);
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  first, held;
    repeat (10) @(negedge sys_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge sys_clk);

    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    reg_rd(0, v);    chk("R1 ctrl", v, 0);
    reg_rd(4, v);    chk("R1 status", v, 0);
    reg_rd(8, v);    chk("R1 ppl", v, 0);
    reg_rd(12, v);   chk("R1 lpf", v, 0);
    reg_rd(16, v);   chk("R1 rate", v, 0);
    reg_rd(20, v);   chk("R1 window", v, 200000000);

    // R6 R7 geometry table walk
    send_vsync();
    for (int i = 0; i < NTBL; i++) begin
      send_lines(TBL_LN[i], TBL_PX[i]);
      send_vsync();
      repeat (20) @(negedge sys_clk);
      reg_rd(8, v);  chk("R6 ppl", v, TBL_PX[i]);
      reg_rd(12, v); chk("R6 lpf", v, TBL_LN[i]);
      reg_rd(4, v);
      chk("R7 res", v, (i > 0 && TBL_PX[i] == TBL_PX[i-1] && TBL_LN[i] == TBL_LN[i-1]) ? 4 : 0);
    end
    chk("R4 nothing captured unarmed", out_valid, 0);

    // R2 arm mid-frame, R3 single shot, R9 busy
    send_vsync();
    send_lines(2, 5);
    reg_wr(0, 1);
    send_lines(2, 5);
    repeat (20) @(negedge sys_clk);
    chk("R2 no bytes from open frame", out_valid, 0);
    send_vsync();
    first = dbyte;
    send_lines(3, 5);
    reg_rd(4, v); chk("R9 busy during capture", v[0], 1);
    send_vsync();
    send_lines(3, 5);
    reg_rd(4, v); chk("R9 idle after single frame", v[0], 0);
    drain("R3 single frame", first, 15);

    // R3 continuous mode
    rearm(1'b1);
    send_vsync();
    first = dbyte;
    send_lines(2, 4);
    send_vsync();
    send_lines(2, 4);
    reg_wr(0, 0); tick(4);
    send_vsync();
    send_lines(2, 4);
    drain("R3 continuous", first, 16);

    // R4 back-pressure hold
    rearm(1'b0);
    send_vsync();
    first = dbyte;
    send_lines(1, 6);
    send_vsync();
    repeat (30) @(negedge sys_clk);
    chk("R4 valid waiting", out_valid, 1);
    held = out_data;
    repeat (10) @(negedge sys_clk);
    chk("R4 valid held", out_valid, 1);
    chk("R4 data held", out_data, held);
    chk("R4 head byte", held, first);
    drain("R4 stream", first, 6);

    // R5 R10 overflow, clear racing with discards
    rearm(1'b0);
    send_vsync();
    first = dbyte;
    fork
      send_lines(20, 30);
      begin
        tick(18 * 33 + 5);
        reg_wr(4, 2);
        repeat (30) @(negedge sys_clk);
        reg_rd(4, v);
        chk("R5 set wins over clear", v[1], 1);
      end
    join
    send_vsync();
    repeat (20) @(negedge sys_clk);
    reg_wr(4, 2);
    reg_rd(4, v); chk("R5 cleared", v[1], 0);
    drain("R10 full depth", first, 512);

    // R8 frame rate window
    fork
      for (int k = 0; k < 30; k++) begin
        cam_frame = 1'b1; tick(2);
        cam_frame = 1'b0; tick(38);
      end
      begin
        reg_wr(20, 2400);
        repeat (2 * 2400 + 20) @(negedge sys_clk);
        reg_rd(16, v);
        chk("R8 rate", v, (v >= 9 && v <= 11) ? v : 10);
        reg_rd(20, v);
        chk("R8 window readback", v, 2400);
      end
    join

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule